// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave with Upper-Half Write Lock

This block is the slave side of a byte-wide serial memory on a two-wire bus. It samples the bus clock and data lines into the system clock domain and finds start and stop conditions. It checks the address byte that follows each start. It then serves an array built from 256-byte blocks, so the block count sets the depth. A transaction that addresses the device for writing carries a one-byte word address and then any number of data bytes. Those bytes land at consecutive locations, wrapping inside a page. A read returns bytes from the current location onward. A read usually follows a repeated start that comes after the word address.

The device answers to a range of bus addresses. The upper four address bits are a fixed device type. Of the three low address bits, those not needed for block selection must match the `chip_sel` strap, and the rest pick the block. When `wp_en` is high, the upper half of the array cannot be written. The data line is open-drain, so the design only asserts `sda_oe` to pull the line low. After a write transaction ends with a stop, a busy timer stands in for programming time. While it runs, the device ignores its address.

Top module: `eep_slave`

## Requirements
- R1: A start condition (data falling while clock is high) restarts address reception from any state. A stop condition (data rising while clock is high) returns the block to idle with `sda_oe` low.
- R2: The address byte is received MSB first, and bit 0 is the direction (0 means the master writes, 1 means it reads). Bits 7:4 must equal 4'b1010. With BLOCKS=2, bits 3:2 must equal `chip_sel[2:1]` and bit 1 selects the block. A non-matching address is not acknowledged.
- R3: For every byte the slave receives while addressed, it drives `sda_oe` high through the ninth clock and releases the line after that clock falls. It never asserts `sda_oe` while the bus clock is high.
- R4: In a write, the byte after the address byte sets the low 8 bits of the location. Each data byte is stored and the location advances. Only the low 4 bits (16-byte page) wrap, so offset 0x0F is followed by 0x00 of the same page.
- R5: In a read, bytes are sent MSB first. The slave pulls the line low for each 0 bit. The location advances after each byte and wraps from the last location of the array to location 0.
- R6: When the master leaves data high on the acknowledge clock after a read byte, the slave stops driving and stays released until the next start.
- R7: A repeated start after the word address, followed by a read address, is accepted without a stop. The read begins at the location just written.
- R8: With `wp_en` high, data bytes aimed at the upper half of the array (location MSB set) are acknowledged but not stored. Writes to the lower half are stored.
- R9: A stop that ends a transaction carrying at least one data byte starts a busy period of BUSY_CYC clocks. During that period the slave acknowledges no address and keeps `sda_oe` low.
- R10: After reset `sda_oe` is low and the block waits for a start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| chip_sel | input | 3 | Strap value compared with the address bits not used for block selection |
| wp_en | input | 1 | High to lock the upper half of the array against writes |
| sda_oe | output | 1 | High to pull the data line low |

## Verification
The acknowledge for a data byte and the decision whether to store that byte happen in the same cycle, on the falling edge that closes the eighth bit. Under write protection these two must split: the line must be pulled low while the write is suppressed. The bench provokes this with protected and unprotected writes issued back to back. It judges the result by the acknowledge seen on the line and by reading the locations back afterwards. It also lands an address poll inside the busy window that a just-finished write opened, and expects that poll to go unacknowledged.

// File: rtl/eep_slave_pkg.sv
package eep_slave_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_RX,
        PH_ACK_OUT,
        PH_TX,
        PH_ACK_IN
    } phase_e;

    typedef enum logic [1:0] {
        RX_DEV,
        RX_WORD,
        RX_DATA
    } rxkind_e;

endpackage

// File: rtl/eep_bus_sync.sv
module eep_bus_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_p,
    output logic stop_p
);
    logic [STAGES:0] scl_q, scl_d;
    logic [STAGES:0] sda_q, sda_d;
    logic scl_now, scl_old, sda_old;

    always_comb begin
        scl_d = {scl_q[STAGES-1:0], scl_i};
        sda_d = {sda_q[STAGES-1:0], sda_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= '1;
            sda_q <= '1;
        end else begin
            scl_q <= scl_d;
            sda_q <= sda_d;
        end
    end

    assign scl_now  = scl_q[STAGES-1];
    assign scl_old  = scl_q[STAGES];
    assign sda_s    = sda_q[STAGES-1];
    assign sda_old  = sda_q[STAGES];
    assign scl_rise = scl_now & ~scl_old;
    assign scl_fall = ~scl_now & scl_old;
    assign start_p  = scl_now & scl_old & sda_old & ~sda_s;
    assign stop_p   = scl_now & scl_old & ~sda_old & sda_s;
endmodule

// File: rtl/eep_store.sv
module eep_store #(
    parameter int DEPTH = 512,
    parameter int AW    = 9
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);
    logic [7:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) cells[waddr] <= wdata;
    end

    assign rdata = cells[raddr];
endmodule

// File: rtl/eep_busy_timer.sv
module eep_busy_timer #(
    parameter int CYC = 400
) (
    input  logic clk,
    input  logic rst_n,
    input  logic kick,
    output logic busy
);
    localparam int CW = $clog2(CYC + 1);
    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (kick)            cnt_d = CW'(CYC);
        else if (cnt_q != 0) cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign busy = (cnt_q != 0);
endmodule

// File: rtl/eep_slave.sv
module eep_slave
    import eep_slave_pkg::*;
#(
    parameter int         BLOCKS     = 2,
    parameter int         PAGE_BYTES = 16,
    parameter int         BUSY_CYC   = 400,
    parameter logic [3:0] DEV_TYPE   = 4'b1010
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    input  logic [2:0] chip_sel,
    input  logic       wp_en,
    output logic       sda_oe
);
    localparam int         BB       = $clog2(BLOCKS);
    localparam int         AW       = 8 + BB;
    localparam int         DEPTH    = 256 * BLOCKS;
    localparam logic [2:0] BLK_MASK = 3'(BLOCKS - 1);
    localparam logic [2:0] SEL_MASK = ~BLK_MASK;
    localparam logic [AW-1:0] PMASK = AW'(PAGE_BYTES - 1);

    typedef struct packed {
        phase_e        ph;
        rxkind_e       kind;
        logic [3:0]    cnt;
        logic [7:0]    sr;
        logic [AW-1:0] ptr;
        logic          oe;
        logic          rw;
        logic          ackin;
        logic          dirty;
    } ctl_t;

    ctl_t q, n;

    logic sda_s, scl_rise, scl_fall, start_p, stop_p;
    logic busy, kick, we;
    logic [7:0] rdata;
    logic id_hit, prot;

    eep_bus_sync #(.STAGES(2)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_i),
        .sda_i    (sda_i),
        .sda_s    (sda_s),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_p  (start_p),
        .stop_p   (stop_p)
    );

    eep_store #(.DEPTH(DEPTH), .AW(AW)) u_store (
        .clk   (clk),
        .we    (we),
        .waddr (q.ptr),
        .wdata (q.sr),
        .raddr (q.ptr),
        .rdata (rdata)
    );

    eep_busy_timer #(.CYC(BUSY_CYC)) u_busy (
        .clk   (clk),
        .rst_n (rst_n),
        .kick  (kick),
        .busy  (busy)
    );

    assign id_hit = (q.sr[7:4] == DEV_TYPE) &&
                    (((q.sr[3:1] ^ chip_sel) & SEL_MASK) == 3'b000);
    assign prot   = wp_en && q.ptr[AW-1];

    always_comb begin
        n    = q;
        we   = 1'b0;
        kick = 1'b0;
        if (start_p) begin
            n.ph   = PH_RX;
            n.kind = RX_DEV;
            n.cnt  = '0;
            n.oe   = 1'b0;
        end else if (stop_p) begin
            n.ph    = PH_IDLE;
            n.oe    = 1'b0;
            kick    = q.dirty;
            n.dirty = 1'b0;
        end else begin
            case (q.ph)
                PH_RX: begin
                    if (scl_rise) begin
                        n.sr  = {q.sr[6:0], sda_s};
                        n.cnt = q.cnt + 1'b1;
                    end else if (scl_fall && q.cnt == 4'd8) begin
                        case (q.kind)
                            RX_DEV: begin
                                if (id_hit && !busy) begin
                                    n.ph  = PH_ACK_OUT;
                                    n.oe  = 1'b1;
                                    n.rw  = q.sr[0];
                                    n.ptr = AW'({q.sr[3:1] & BLK_MASK, q.ptr[7:0]});
                                end else begin
                                    n.ph = PH_IDLE;
                                end
                            end
                            RX_WORD: begin
                                n.ptr[7:0] = q.sr;
                                n.ph       = PH_ACK_OUT;
                                n.oe       = 1'b1;
                            end
                            default: begin
                                we      = !prot;
                                n.dirty = 1'b1;
                                n.ptr   = (q.ptr & ~PMASK) | ((q.ptr + 1'b1) & PMASK);
                                n.ph    = PH_ACK_OUT;
                                n.oe    = 1'b1;
                            end
                        endcase
                    end
                end
                PH_ACK_OUT: begin
                    if (scl_fall) begin
                        n.cnt = '0;
                        if (q.kind == RX_DEV && q.rw) begin
                            n.ph  = PH_TX;
                            n.sr  = rdata;
                            n.ptr = q.ptr + 1'b1;
                            n.oe  = ~rdata[7];
                        end else begin
                            n.ph   = PH_RX;
                            n.oe   = 1'b0;
                            n.kind = (q.kind == RX_DEV) ? RX_WORD : RX_DATA;
                        end
                    end
                end
                PH_TX: begin
                    if (scl_fall) begin
                        if (q.cnt == 4'd7) begin
                            n.ph = PH_ACK_IN;
                            n.oe = 1'b0;
                        end else begin
                            n.sr  = {q.sr[6:0], 1'b0};
                            n.oe  = ~q.sr[6];
                            n.cnt = q.cnt + 1'b1;
                        end
                    end
                end
                PH_ACK_IN: begin
                    if (scl_rise) begin
                        n.ackin = sda_s;
                    end else if (scl_fall) begin
                        if (!q.ackin) begin
                            n.ph  = PH_TX;
                            n.cnt = '0;
                            n.sr  = rdata;
                            n.ptr = q.ptr + 1'b1;
                            n.oe  = ~rdata[7];
                        end else begin
                            n.ph = PH_IDLE;
                            n.oe = 1'b0;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.ph    <= PH_IDLE;
            q.kind  <= RX_DEV;
        end else begin
            q <= n;
        end
    end

    assign sda_oe = q.oe;
endmodule

// File: rtl/eep_slave_chk.sv
module eep_slave_chk (
    input logic clk,
    input logic rst_n,
    input logic scl_i,
    input logic sda_oe,
    input logic start_p,
    input logic stop_p,
    input logic busy
);
    AST_OE_RISE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !scl_i); // R3
    AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        stop_p |=> !sda_oe); // R1
    AST_START_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        start_p |=> !sda_oe); // R7
    AST_BUSY_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !sda_oe); // R9
    AST_BUSY_AFTER_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(stop_p)); // R9
endmodule

bind eep_slave eep_slave_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .scl_i   (scl_i),
    .sda_oe  (sda_oe),
    .start_p (start_p),
    .stop_p  (stop_p),
    .busy    (busy)
);

// File: tb/eep_slave_test.sv
module eep_slave_test;
    localparam int CLK_NS = 10;
    localparam int Q      = 8;
    localparam int BUSY   = 400;
    localparam int DEPTH  = 512;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic sda_m = 1'b1;
    logic [2:0] chip_sel = 3'b000;
    logic wp_en = 1'b0;
    logic sda_oe;
    logic sda_bus;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;
    logic [7:0] mdl [DEPTH];

    always #(CLK_NS/2) clk = ~clk;
    assign sda_bus = sda_m & ~sda_oe;

    eep_slave uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl),
        .sda_i    (sda_bus),
        .chip_sel (chip_sel),
        .wp_en    (wp_en),
        .sda_oe   (sda_oe)
    );

    task automatic cmp(input logic act, input logic exp, input string req);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: sda_oe=%0b expected %0b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic wait_n(input int k);
        repeat (k) @(negedge clk);
    endtask

    task automatic bit_cycle(input logic drv, input logic exp_oe, input string req);
        wait_n(Q);
        sda_m = drv;
        wait_n(Q);
        scl = 1'b1;
        for (int k = 0; k < 2*Q; k++) begin
            @(negedge clk);
            cmp(sda_oe, exp_oe, req);
        end
        scl = 1'b0;
    endtask

    task automatic bus_start();
        wait_n(Q);
        sda_m = 1'b1;
        wait_n(Q);
        scl = 1'b1;
        wait_n(Q);
        sda_m = 1'b0;
        wait_n(Q);
        scl = 1'b0;
    endtask

    task automatic bus_stop(input string req);
        wait_n(Q);
        sda_m = 1'b0;
        wait_n(Q);
        scl = 1'b1;
        for (int k = 0; k < Q; k++) begin
            @(negedge clk);
            cmp(sda_oe, 1'b0, req);
        end
        sda_m = 1'b1;
        wait_n(2*Q);
    endtask

    task automatic send_byte(input logic [7:0] b, input logic exp_ack, input string req);
        for (int i = 7; i >= 0; i--) bit_cycle(b[i], 1'b0, req);
        bit_cycle(1'b1, exp_ack, req);
    endtask

    task automatic read_byte(input logic [7:0] exp, input logic nack, input string req);
        for (int i = 7; i >= 0; i--) bit_cycle(1'b1, ~exp[i], req);
        bit_cycle(nack, 1'b0, req);
    endtask

    function automatic logic [7:0] dev(input logic blk, input logic rd);
        return {4'b1010, 2'b00, blk, rd};
    endfunction

    task automatic write_txn(input logic blk, input logic [7:0] word,
                             input logic [7:0] data [$], input string req);
        int p;
        p = {blk, word};
        bus_start();
        send_byte(dev(blk, 1'b0), 1'b1, "R2");
        send_byte(word, 1'b1, "R3");
        foreach (data[i]) begin
            send_byte(data[i], 1'b1, req);
            if (!(wp_en && p >= DEPTH/2)) mdl[p] = data[i];
            p = (p & ~15) | ((p + 1) & 15);
        end
        bus_stop("R1");
    endtask

    task automatic read_txn(input logic blk, input logic [7:0] word,
                            input int cnt, input string req);
        int p;
        p = {blk, word};
        bus_start();
        send_byte(dev(blk, 1'b0), 1'b1, "R2");
        send_byte(word, 1'b1, "R3");
        bus_start();
        send_byte(dev(blk, 1'b1), 1'b1, "R7");
        for (int i = 0; i < cnt; i++) begin
            read_byte(mdl[p], (i == cnt - 1), req);
            p = (p + 1) % DEPTH;
        end
        bus_stop("R6");
    endtask

    initial begin
        logic [7:0] bytes [$];
        wait_n(4);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            cmp(sda_oe, 1'b0, "R10");
        end
        rst_n = 1'b1;
        wait_n(4);
        cmp(sda_oe, 1'b0, "R10");

        // R2: strap mismatch in bit 3 is not acknowledged
        bus_start();
        send_byte(8'b1010_1000, 1'b0, "R2");
        bus_stop("R1");
        // R2: wrong device type
        bus_start();
        send_byte(8'b0110_0000, 1'b0, "R2");
        bus_stop("R1");

        // R4: page write crossing the 16-byte page boundary
        bytes = '{8'hA1, 8'hB2, 8'hC3, 8'hD4};
        write_txn(1'b0, 8'h0E, bytes, "R4");
        // R9: poll inside the busy window
        bus_start();
        send_byte(dev(1'b0, 1'b0), 1'b0, "R9");
        bus_stop("R9");
        wait_n(BUSY + 20);

        // R7 / R4: read back across the wrap point
        read_txn(1'b0, 8'h0E, 2, "R4");
        read_txn(1'b0, 8'h00, 2, "R4");

        // R5: sequential read wraps from top of array to 0
        bytes = '{8'h5A};
        write_txn(1'b1, 8'hFF, bytes, "R3");
        wait_n(BUSY + 20);
        read_txn(1'b1, 8'hFF, 3, "R5");

        // R8: protect upper half
        bytes = '{8'h11};
        write_txn(1'b1, 8'h10, bytes, "R3");
        wait_n(BUSY + 20);
        wp_en = 1'b1;
        bytes = '{8'h55, 8'h77};
        write_txn(1'b1, 8'h10, bytes, "R8");
        wait_n(BUSY + 20);
        bytes = '{8'h66};
        write_txn(1'b0, 8'h20, bytes, "R8");
        wait_n(BUSY + 20);
        read_txn(1'b1, 8'h10, 2, "R8");
        read_txn(1'b0, 8'h20, 1, "R8");

        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: run hung, actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule